// File: doc/BRIEF.md
# Pointer Authentication Sign/Verify Unit

This unit carries out the four pointer-authentication hint operations on 64-bit instruction pointers. The core supplies the instruction word, the pointer operand, the modifier operand and a one-bit key number. The unit recognises two sign and two authenticate encodings, each in a general-register form and a link-register/stack-pointer form. It forms the extended (canonical) pointer and presents it, with the modifier, to an external cipher. When the cipher answers over a valid/ready handshake, the unit returns the signed or authenticated pointer and the index of the register that receives it.

The code field sits in pointer bits 54:48. Bit 55 selects the address range and is never overwritten by a code. The top byte is a tag and passes through unchanged. A failed authentication does not trap. Instead the pointer comes back extended, with a key-dependent error pattern in bits 54:53. Signing a pointer that is not canonical deliberately corrupts the code, so the pointer can never authenticate.

Only one operation is in flight at a time. Words the unit does not recognise raise a one-cycle "not handled" flag and produce no result.

Top module: `pac_hint_unit`

## Requirements
- R1: The words 0xD503211F (sign, general form), 0xD503219F (authenticate, general form), 0xD503233F (sign, LR/SP form) and 0xD50323BF (authenticate, LR/SP form) are accepted when `op_valid` is high and `busy` is low. `busy` rises in the next cycle and stays high until a response handshake (`rsp_valid` and `rsp_ready`) takes place.
- R2: Any other word offered while idle raises `not_handled` for exactly one cycle, in the cycle after it was offered. It leaves `busy` low and produces no result.
- R3: While busy, `cph_valid` and `rsp_ready` are high and `cph_mod` equals the modifier. `cph_ptr` equals the extended pointer: bits 54:48 are all copies of bit 55, and all other bits are the input pointer's. Both outputs stay constant until the response arrives.
- R4: `res_reg` is 17 for the general forms and 30 for the LR/SP forms.
- R5: Signing a pointer whose bits 55:48 are all zero or all one gives this result: input bits 63:55 in bits 63:55, cipher bits 54:48 in bits 54:48, and input bits 47:0 in bits 47:0.
- R6: Signing a pointer whose bits 55:48 are mixed inverts cipher bit 54 before it is inserted. The rest of the result is formed as in R5.
- R7: Authenticating returns the extended pointer when cipher bits 54:48 equal pointer bits 54:48.
- R8: On an authentication mismatch, the result is the extended pointer with bits 54:53 set to 01 for key 0 and 10 for key 1. For example, 0x0000000012345678 with a wrong code under key 0 returns 0x0020000012345678.
- R9: `res_valid` is high for exactly one cycle, the cycle after the response handshake. `busy` is low in that same cycle.
- R10: An operation offered while busy is ignored: the cipher request and the eventual result still belong to the operation already in flight.
- R11: After reset, `busy`, `res_valid`, `not_handled` and `cph_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_word | input | 32 | Instruction word |
| op_ptr | input | 64 | Pointer operand |
| op_mod | input | 64 | Modifier operand |
| op_key | input | 1 | Key number for the error pattern |
| busy | output | 1 | Operation in flight |
| not_handled | output | 1 | One-cycle flag for an unrecognised word |
| cph_valid | output | 1 | Cipher request valid |
| cph_ptr | output | 64 | Extended pointer for the cipher |
| cph_mod | output | 64 | Modifier for the cipher |
| rsp_valid | input | 1 | Cipher result valid |
| rsp_ready | output | 1 | Unit can take the cipher result |
| rsp_data | input | 64 | Cipher result |
| res_valid | output | 1 | One-cycle result strobe |
| res_ptr | output | 64 | Signed or authenticated pointer |
| res_reg | output | 5 | Destination register index |

## Verification
The assertions take for granted that the cipher raises `rsp_valid` only while a request is outstanding, and that it may take any number of cycles to do so. They check the handshake, the result pulse and the destination index, not the cipher value itself. The stimulus drives `rsp_valid` only after `busy` is seen high, and it sometimes holds the response back for several cycles. It offers operations both while idle and deliberately while busy.

// File: rtl/pac_hint_unit.sv
module pac_hint_unit #(
  parameter int PTR_W   = 64,
  parameter int WORD_W  = 32,
  parameter int CODE_LO = 48,
  parameter int SEL_BIT = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] op_word,
  input  logic [PTR_W-1:0]  op_ptr,
  input  logic [PTR_W-1:0]  op_mod,
  input  logic              op_key,
  output logic              busy,
  output logic              not_handled,
  output logic              cph_valid,
  output logic [PTR_W-1:0]  cph_ptr,
  output logic [PTR_W-1:0]  cph_mod,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [PTR_W-1:0]  rsp_data,
  output logic              res_valid,
  output logic [PTR_W-1:0]  res_ptr,
  output logic [4:0]        res_reg
);
  localparam int CODE_W = SEL_BIT - CODE_LO;
  localparam int CODE_HI = SEL_BIT - 1;
  localparam logic [WORD_W-1:0] W_SIGN_GEN = 32'hD503211F;
  localparam logic [WORD_W-1:0] W_AUTH_GEN = 32'hD503219F;
  localparam logic [WORD_W-1:0] W_SIGN_LS  = 32'hD503233F;
  localparam logic [WORD_W-1:0] W_AUTH_LS  = 32'hD50323BF;
  localparam logic [4:0] REG_GEN = 5'd17;
  localparam logic [4:0] REG_LS  = 5'd30;

  logic             hit, hit_auth, hit_ls;
  logic             q_auth, q_key;
  logic [4:0]       q_reg;
  logic [PTR_W-1:0] q_ptr, q_mod;

  always_comb begin
    hit = 1'b1;
    hit_auth = 1'b0;
    hit_ls = 1'b0;
    case (op_word)
      W_SIGN_GEN: ;
      W_AUTH_GEN: hit_auth = 1'b1;
      W_SIGN_LS:  hit_ls = 1'b1;
      W_AUTH_LS:  begin hit_auth = 1'b1; hit_ls = 1'b1; end
      default:    hit = 1'b0;
    endcase
  end

  wire accept = op_valid && !busy && hit;
  wire done   = busy && rsp_valid;

  wire [PTR_W-1:0] ext_ptr = {q_ptr[PTR_W-1:SEL_BIT], {CODE_W{q_ptr[SEL_BIT]}},
                              q_ptr[CODE_LO-1:0]};
  wire             canon = (&q_ptr[SEL_BIT:CODE_LO]) || !(|q_ptr[SEL_BIT:CODE_LO]);
  wire [CODE_W-1:0] sign_code = rsp_data[CODE_HI:CODE_LO] ^ {!canon, {(CODE_W-1){1'b0}}};
  wire [PTR_W-1:0] signed_ptr = {q_ptr[PTR_W-1:SEL_BIT], sign_code, q_ptr[CODE_LO-1:0]};
  wire             code_ok = rsp_data[CODE_HI:CODE_LO] == q_ptr[CODE_HI:CODE_LO];
  wire [1:0]       err_pat = q_key ? 2'b10 : 2'b01;
  wire [PTR_W-1:0] auth_ptr = code_ok ? ext_ptr :
                              {ext_ptr[PTR_W-1:SEL_BIT], err_pat, ext_ptr[CODE_HI-2:0]};

  assign cph_valid = busy;
  assign rsp_ready = busy;
  assign cph_ptr   = ext_ptr;
  assign cph_mod   = q_mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      not_handled <= 1'b0;
      res_valid <= 1'b0;
      res_ptr <= '0;
      res_reg <= '0;
      q_auth <= 1'b0;
      q_key <= 1'b0;
      q_reg <= '0;
      q_ptr <= '0;
      q_mod <= '0;
    end else begin
      not_handled <= op_valid && !busy && !hit;
      res_valid <= done;
      if (accept) begin
        busy <= 1'b1;
        q_auth <= hit_auth;
        q_key <= op_key;
        q_reg <= hit_ls ? REG_LS : REG_GEN;
        q_ptr <= op_ptr;
        q_mod <= op_mod;
      end else if (done) begin
        busy <= 1'b0;
        res_ptr <= q_auth ? auth_ptr : signed_ptr;
        res_reg <= q_reg;
      end
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && hit) |=> busy);
  p_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    not_handled |-> (!busy && !res_valid));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> (busy && $stable(cph_ptr) && $stable(cph_mod)));
  p_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_reg == REG_GEN || res_reg == REG_LS));
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsp_valid) |=> (res_valid && !busy));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: tb/test_pac_hint_unit.sv
module test_pac_hint_unit;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_key = 0, rsp_valid = 0;
  logic [31:0] op_word = '0;
  logic [63:0] op_ptr = '0, op_mod = '0, rsp_data = '0;
  logic busy, not_handled, cph_valid, rsp_ready, res_valid;
  logic [63:0] cph_ptr, cph_mod, res_ptr;
  logic [4:0] res_reg;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pac_hint_unit i_pac_hint_unit (.*);

  typedef struct packed {
    logic [31:0] word;
    logic [63:0] ptr;
    logic [63:0] mod;
    logic        key;
    logic [63:0] cph;
    logic [63:0] ext;
    logic [63:0] exp;
    logic [4:0]  rg;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'hD503211F, 64'h0000000012345678, 64'h477D469DEC0B8768, 1'b0, 64'h123456789ABCDEF0,
      64'h0000000012345678, 64'h0034000012345678, 5'd17},
    '{32'hD503233F, 64'hAB80000000001000, 64'h477D469DEC0B8760, 1'b0, 64'h0011000000000000,
      64'hABFF000000001000, 64'hABD1000000001000, 5'd30},
    '{32'hD503211F, 64'hFFFF800000000040, 64'h0000000000000001, 1'b0, 64'h0005000000000000,
      64'hFFFF800000000040, 64'hFF85800000000040, 5'd17},
    '{32'hD503211F, 64'h0001000000000000, 64'h0000000000000002, 1'b0, 64'h007F000000000000,
      64'h0000000000000000, 64'h003F000000000000, 5'd17},
    '{32'hD503219F, 64'h0034000012345678, 64'h477D469DEC0B8768, 1'b0, 64'h123456789ABCDEF0,
      64'h0000000012345678, 64'h0000000012345678, 5'd17},
    '{32'hD50323BF, 64'h0034000012345678, 64'h477D469DEC0B8760, 1'b0, 64'h0000000000000000,
      64'h0000000012345678, 64'h0020000012345678, 5'd30},
    '{32'hD50323BF, 64'h0034000012345678, 64'h477D469DEC0B8760, 1'b1, 64'h0000000000000000,
      64'h0000000012345678, 64'h0040000012345678, 5'd30},
    '{32'hD503219F, 64'h12D5000000000008, 64'h0000000000000003, 1'b1, 64'h0055000000000000,
      64'h12FF000000000008, 64'h12FF000000000008, 5'd17},
    '{32'hD503219F, 64'h12D5000000000008, 64'h0000000000000003, 1'b1, 64'h0000000000000000,
      64'h12FF000000000008, 64'h12DF000000000008, 5'd17}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [31:0] w, input logic [63:0] p, input logic [63:0] m,
                       input logic k);
    @(negedge clk);
    op_valid = 1; op_word = w; op_ptr = p; op_mod = m; op_key = k;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic respond(input logic [63:0] d);
    rsp_valid = 1; rsp_data = d;
    @(negedge clk);
    rsp_valid = 0; rsp_data = '0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 res_valid", res_valid, 0);
    chk("R11 not_handled", not_handled, 0);
    chk("R11 cph_valid", cph_valid, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      offer(VEC[i].word, VEC[i].ptr, VEC[i].mod, VEC[i].key);
      chk("R1 busy", busy, 1);
      chk("R3 cph_valid", {cph_valid, rsp_ready}, 2'b11);
      chk("R3 cph_ptr", cph_ptr, VEC[i].ext);
      chk("R3 cph_mod", cph_mod, VEC[i].mod);
      respond(VEC[i].cph);
      chk("R9 res_valid", {res_valid, busy}, 2'b10);
      chk("R5 R6 R7 R8 res_ptr", res_ptr, VEC[i].exp);
      chk("R4 res_reg", res_reg, VEC[i].rg);
      @(negedge clk);
      chk("R9 single pulse", res_valid, 0);
    end

    // R2: a word inside the hint group and a plain no-op word
    foreach (VEC[j]) if (j < 2) begin
      offer(j == 0 ? 32'hD503215F : 32'hD503201F, 64'h1, 64'h2, 1'b0);
      chk("R2 flag", not_handled, 1);
      chk("R2 no busy", busy, 0);
      chk("R2 no result", res_valid, 0);
      @(negedge clk);
      chk("R2 one cycle", not_handled, 0);
    end

    // R1 and R10: a slow cipher, with a second offer while busy
    offer(32'hD50323BF, 64'h0034000012345678, 64'h55, 1'b0);
    offer(32'hD503211F, 64'h0001000000000000, 64'h77, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 busy held", busy, 1);
    chk("R10 cph_ptr kept", cph_ptr, 64'h0000000012345678);
    chk("R10 cph_mod kept", cph_mod, 64'h55);
    respond(64'h0);
    chk("R10 result of first op", res_ptr, 64'h0020000012345678);
    chk("R10 reg of first op", res_reg, 5'd30);
    @(negedge clk);
    chk("R10 no second op", busy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule